// File: doc/BRIEF.md
# Fat-Tree Virtual-Channel Switch

This block is the central crossbar of a dataflow network. Four source ports feed four destination ports, and each destination port holds two virtual-channel FIFOs, which gives eight output channels in total. Traffic moves as wormhole packets of 8-bit flits. The first flit of a packet is a header whose port field chooses the destination port. Any later flit equal to 0xFF is the tail and closes the packet.

A coordination unit keeps a binding between each source and a channel. A round-robin arbitration unit admits one eligible source per cycle. That source's flit crosses the shared crossbar in its time slot and enters the bound channel FIFO. A source that cannot proceed is stalled and keeps its flit. Downstream logic drains each channel through a show-ahead read port.

Top module: `fts_switch`

## Requirements
- R1: While reset is held and on the first cycle after it, every `out_valid` bit is 0 and every channel is free. With all `in_valid` low, `in_ready` is 0.
- R2: A flit presented by an unbound source is its header. Header bits [5:4] give the destination port p, and the flit is written into channel 2p or channel 2p+1. Header bits [7:6] (data id) do not affect routing.
- R3: When a header is accepted, the switch picks channel 2p if that channel is unbound and not full. Otherwise it picks channel 2p+1 under the same conditions.
- R4: Once a header is accepted, every later flit from that source goes to the same channel, up to and including the tail. No other source writes that channel while it is bound.
- R5: A flit equal to 0xFF from a bound source is written and then ends the binding. After that the channel can be picked for a new header, and the source's next flit is treated as a header.
- R6: A header whose two destination channels are both bound or full is stalled. So is a flit from a bound source whose channel is full. A stalled flit has `in_ready` low, is kept by the source, and is neither lost nor duplicated.
- R7: At most one source is accepted per cycle, and only if its `in_valid` is high. Arbitration is round-robin: the search starts at the source after the last one accepted (source 0 after reset) and takes the first eligible one.
- R8: A flit accepted at a clock edge is visible on `out_valid`/`out_flit` of its channel right after that edge, if it is the oldest entry there.
- R9: Each channel delivers flits in the order they were written. `out_pop` on an empty channel is ignored. A write to a full channel is refused even if a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_IN (4) | Source i presents a flit |
| in_flit | input | NUM_IN*FLIT_W (32) | Flit of source i in bits [8i+7:8i] |
| in_ready | output | NUM_IN (4) | Flit of source i is taken at this edge |
| out_pop | input | NUM_OUT*NUM_VC (8) | Remove the oldest flit of channel c (c = 2*port + vc) |
| out_valid | output | NUM_OUT*NUM_VC (8) | Channel c holds at least one flit |
| out_flit | output | NUM_OUT*NUM_VC*FLIT_W (64) | Oldest flit of channel c in bits [8c+7:8c] |

## Verification
A wrong binding shows up as a flit landing in another channel's `out_valid` bit on the very next cycle. Channel release errors appear a few cycles later, either as a header that stalls with a free channel in sight or as two packets interleaved inside one channel's read sequence. A skewed round-robin pointer changes which `in_ready` bit rises in the first contended cycle. A FIFO pointer or count fault appears as a wrong `out_flit` value or a wrong `out_valid` on the next pop. The bench runs a queue-based model of the channels and bindings beside the switch and compares every output on every cycle, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/fts_pkg.sv
package fts_pkg;

   // Occupancy view of one output virtual channel
   typedef enum logic [1:0] {
      VC_IDLE  = 2'd0,   // unbound, nothing stored
      VC_EMPTY = 2'd1,   // bound to a source, nothing stored yet
      VC_BUSY  = 2'd2,   // bound to a source, flits stored
      VC_READY = 2'd3    // unbound, completed packets waiting
   } vc_state_t;

   function automatic logic vc_allocatable(vc_state_t st, logic full);
      return ((st == VC_IDLE) || (st == VC_READY)) && !full;
   endfunction

endpackage

// File: rtl/fts_vc_fifo.sv
module fts_vc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("fts_vc_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/fts_rr_arb.sv
module fts_rr_arb #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] grant_idx,
   output logic          grant_any
);
   if (N < 1) begin : g_bad_n
      $error("fts_rr_arb: N must be positive");
   end

   if (N == 1) begin : g_single
      assign grant     = req;
      assign grant_idx = '0;
      assign grant_any = req[0];
   end else begin : g_rotate
      logic [IW-1:0] ptr_q;

      always_comb begin
         grant     = '0;
         grant_idx = '0;
         grant_any = 1'b0;
         for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr_q) + k;
            if (c >= N) c = c - N;
            if (!grant_any && req[c]) begin
               grant[c]  = 1'b1;
               grant_idx = IW'(c);
               grant_any = 1'b1;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else if (grant_any) begin
            ptr_q <= (grant_idx == IW'(N - 1)) ? '0 : grant_idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fts_coord.sv
module fts_coord
   import fts_pkg::*;
#(
   parameter int                NUM_IN    = 4,
   parameter int                NUM_OUT   = 4,
   parameter int                NUM_VC    = 2,
   parameter int                FLIT_W    = 8,
   parameter int                PORT_LSB  = 4,
   parameter logic [FLIT_W-1:0] TAIL_FLIT = '1,
   localparam int NUM_CH = NUM_OUT * NUM_VC,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int PORT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
   localparam int IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IN-1:0]        in_valid,
   input  logic [NUM_IN*FLIT_W-1:0] in_flit,
   input  logic [NUM_CH-1:0]        ch_full,
   input  logic [NUM_CH-1:0]        ch_empty,
   input  logic                     grant_any,
   input  logic [IW-1:0]            grant_idx,
   output logic [NUM_IN-1:0]        req,
   output logic [NUM_IN*CH_W-1:0]   in_ch
);
   // binding state
   logic [NUM_IN-1:0] bound_q;
   logic [CH_W-1:0]   bound_ch_q [NUM_IN];
   logic [NUM_CH-1:0] owned_q;

   // channel view
   vc_state_t         ch_state [NUM_CH];
   logic [NUM_CH-1:0] ch_avail;

   // per-source candidate
   logic [PORT_W-1:0] hdr_port [NUM_IN];
   logic [NUM_IN-1:0] pick_ok;
   logic [CH_W-1:0]   pick_ch  [NUM_IN];
   logic [CH_W-1:0]   tgt_ch   [NUM_IN];
   logic [FLIT_W-1:0] gflit;

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         case ({owned_q[c], ch_empty[c]})
            2'b01:   ch_state[c] = VC_IDLE;
            2'b00:   ch_state[c] = VC_READY;
            2'b11:   ch_state[c] = VC_EMPTY;
            default: ch_state[c] = VC_BUSY;
         endcase
         ch_avail[c] = vc_allocatable(ch_state[c], ch_full[c]);
      end
   end

   // lowest-numbered allocatable channel of the destination port
   always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
         hdr_port[i] = in_flit[i*FLIT_W+PORT_LSB +: PORT_W];
         pick_ok[i]  = 1'b0;
         pick_ch[i]  = '0;
         for (int v = 0; v < NUM_VC; v++) begin
            if (!pick_ok[i] && ch_avail[int'(hdr_port[i])*NUM_VC + v]) begin
               pick_ok[i] = 1'b1;
               pick_ch[i] = CH_W'(int'(hdr_port[i])*NUM_VC + v);
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
         if (bound_q[i]) begin
            tgt_ch[i] = bound_ch_q[i];
            req[i]    = in_valid[i] && !ch_full[bound_ch_q[i]];
         end else begin
            tgt_ch[i] = pick_ch[i];
            req[i]    = in_valid[i] && pick_ok[i];
         end
      end
   end

   for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_out
      assign in_ch[gi*CH_W +: CH_W] = tgt_ch[gi];
   end

   assign gflit = in_flit[int'(grant_idx)*FLIT_W +: FLIT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bound_q <= '0;
         owned_q <= '0;
         for (int i = 0; i < NUM_IN; i++) bound_ch_q[i] <= '0;
      end else if (grant_any) begin
         if (!bound_q[grant_idx]) begin
            bound_q[grant_idx]          <= 1'b1;
            bound_ch_q[grant_idx]       <= tgt_ch[grant_idx];
            owned_q[tgt_ch[grant_idx]]  <= 1'b1;
         end else if (gflit == TAIL_FLIT) begin
            bound_q[grant_idx]              <= 1'b0;
            owned_q[bound_ch_q[grant_idx]]  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fts_switch.sv
module fts_switch #(
   parameter int                NUM_IN     = 4,
   parameter int                NUM_OUT    = 4,
   parameter int                NUM_VC     = 2,
   parameter int                FLIT_W     = 8,
   parameter int                FIFO_DEPTH = 4,
   parameter int                PORT_LSB   = 4,
   parameter logic [FLIT_W-1:0] TAIL_FLIT  = '1,
   localparam int NUM_CH = NUM_OUT * NUM_VC,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int PORT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
   localparam int IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IN-1:0]        in_valid,
   input  logic [NUM_IN*FLIT_W-1:0] in_flit,
   output logic [NUM_IN-1:0]        in_ready,
   input  logic [NUM_CH-1:0]        out_pop,
   output logic [NUM_CH-1:0]        out_valid,
   output logic [NUM_CH*FLIT_W-1:0] out_flit
);
   // elaboration-time parameter checks
   if ((NUM_OUT & (NUM_OUT - 1)) != 0) begin : g_bad_out
      $error("fts_switch: NUM_OUT must be a power of two");
   end
   if ((NUM_IN & (NUM_IN - 1)) != 0) begin : g_bad_in
      $error("fts_switch: NUM_IN must be a power of two");
   end
   if (PORT_LSB + PORT_W > FLIT_W) begin : g_bad_field
      $error("fts_switch: port field does not fit in a flit");
   end
   if (NUM_VC < 1 || NUM_CH < 2) begin : g_bad_vc
      $error("fts_switch: need at least two output channels");
   end

   logic [NUM_IN-1:0]      arb_req;
   logic [NUM_IN-1:0]      arb_grant;
   logic [IW-1:0]          grant_idx;
   logic                   grant_any;
   logic [NUM_IN*CH_W-1:0] in_ch;
   logic [NUM_CH-1:0]      ch_full, ch_empty, ch_push;
   logic [CH_W-1:0]        xbar_ch;
   logic [FLIT_W-1:0]      xbar_flit;

   fts_coord #(
      .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_VC(NUM_VC),
      .FLIT_W(FLIT_W), .PORT_LSB(PORT_LSB), .TAIL_FLIT(TAIL_FLIT)
   ) u_coord (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_flit   (in_flit),
      .ch_full   (ch_full),
      .ch_empty  (ch_empty),
      .grant_any (grant_any),
      .grant_idx (grant_idx),
      .req       (arb_req),
      .in_ch     (in_ch)
   );

   fts_rr_arb #(.N(NUM_IN)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (arb_req),
      .grant     (arb_grant),
      .grant_idx (grant_idx),
      .grant_any (grant_any)
   );

   assign in_ready = arb_grant;

   // time-slotted crossbar: the single winner of this slot drives the shared path
   assign xbar_ch   = in_ch[int'(grant_idx)*CH_W +: CH_W];
   assign xbar_flit = in_flit[int'(grant_idx)*FLIT_W +: FLIT_W];

   for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
      assign ch_push[gc]   = grant_any && (xbar_ch == CH_W'(gc));
      assign out_valid[gc] = !ch_empty[gc];

      fts_vc_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (ch_push[gc]),
         .wdata (xbar_flit),
         .pop   (out_pop[gc]),
         .rdata (out_flit[gc*FLIT_W +: FLIT_W]),
         .empty (ch_empty[gc]),
         .full  (ch_full[gc])
      );
   end

endmodule

// File: rtl/fts_switch_chk.sv
module fts_switch_chk #(
   parameter int NUM_IN  = 4,
   parameter int NUM_CH  = 8,
   parameter int FLIT_W  = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_IN-1:0]        in_valid,
   input logic [NUM_IN-1:0]        in_ready,
   input logic [NUM_CH-1:0]        out_pop,
   input logic [NUM_CH-1:0]        out_valid,
   input logic [NUM_CH*FLIT_W-1:0] out_flit
);
   // R7: one crossbar slot per cycle
   a_r7_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   // R7: acceptance only for a presented flit
   a_r7_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready & ~in_valid) == '0);

   // R8: an accepted flit makes some channel non-empty on the next cycle
   a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready != '0) |=> (out_valid != '0));

   for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
      // R9: popping an empty channel with no write leaves it empty
      a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (!out_valid[gc] && in_ready == '0) |=> !out_valid[gc]);

      // R9: without a pop, the oldest flit stays in place
      a_r9_head_held: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[gc] && !out_pop[gc]) |=>
            (out_valid[gc] && $stable(out_flit[gc*FLIT_W +: FLIT_W])));
   end

endmodule

bind fts_switch fts_switch_chk #(
   .NUM_IN (NUM_IN),
   .NUM_CH (NUM_OUT * NUM_VC),
   .FLIT_W (FLIT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_pop   (out_pop),
   .out_valid (out_valid),
   .out_flit  (out_flit)
);

// File: tb/tb_fts_switch.sv
`timescale 1ns/1ps
module tb_fts_switch;
   localparam int NI    = 4;
   localparam int NC    = 8;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NI-1:0] in_valid;
   logic [NI*8-1:0] in_flit;
   logic [NI-1:0] in_ready;
   logic [NC-1:0] out_pop;
   logic [NC-1:0] out_valid;
   logic [NC*8-1:0] out_flit;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   fts_switch dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
      .out_pop(out_pop), .out_valid(out_valid), .out_flit(out_flit)
   );

   // stimulus queues and reference model
   logic [7:0] sq [NI][$];
   logic [7:0] mq [NC][$];
   bit         mb    [NI];
   int         mbch  [NI];
   bit         mown  [NC];
   int         mptr;

   int         gate_mod  = 0;
   bit         rand_pop  = 1'b0;
   logic [NC-1:0] pop_mask = '0;

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   task automatic step();
      logic [NI-1:0] req;
      logic [NI-1:0] exp_rdy;
      int tgt [NI];
      int win;
      logic [7:0] f;
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
         bit v;
         v = (sq[i].size() > 0) && (gate_mod == 0 || ($urandom % gate_mod) != 0);
         in_valid[i] = v;
         in_flit[i*8 +: 8] = v ? sq[i][0] : 8'h00;
      end
      for (int k = 0; k < NC; k++)
         out_pop[k] = pop_mask[k] || (rand_pop && ($urandom % 3) == 0);
      #1;
      // eligibility from the requirements
      for (int i = 0; i < NI; i++) begin
         req[i] = 1'b0;
         tgt[i] = -1;
         if (in_valid[i]) begin
            if (mb[i]) begin
               tgt[i] = mbch[i];
               req[i] = mq[tgt[i]].size() < DEPTH;
            end else begin
               int p;
               p = int'(in_flit[i*8+4 +: 2]);
               for (int v = 0; v < 2; v++)
                  if (tgt[i] < 0 && !mown[p*2+v] && mq[p*2+v].size() < DEPTH) tgt[i] = p*2+v;
               req[i] = (tgt[i] >= 0);
            end
         end
      end
      win = -1;
      for (int k = 0; k < NI; k++) begin
         int c;
         c = (mptr + k) % NI;
         if (win < 0 && req[c]) win = c;
      end
      exp_rdy = '0;
      if (win >= 0) exp_rdy[win] = 1'b1;
      chk(in_ready == exp_rdy, "R6 R7 in_ready", 64'(in_ready), 64'(exp_rdy));
      for (int k = 0; k < NC; k++) begin
         bit ev;
         ev = mq[k].size() > 0;
         chk(out_valid[k] == ev, "R8 out_valid", 64'(out_valid[k]), 64'(ev));
         if (ev) chk(out_flit[k*8 +: 8] == mq[k][0], "R9 out_flit", 64'(out_flit[k*8 +: 8]), 64'(mq[k][0]));
      end
      // advance model to the state after the coming edge
      for (int k = 0; k < NC; k++)
         if (out_pop[k] && mq[k].size() > 0) void'(mq[k].pop_front());
      if (win >= 0) begin
         f = in_flit[win*8 +: 8];
         mq[tgt[win]].push_back(f);
         if (!mb[win]) begin
            mb[win] = 1'b1; mbch[win] = tgt[win]; mown[tgt[win]] = 1'b1;
         end else if (f == 8'hFF) begin
            mb[win] = 1'b0; mown[mbch[win]] = 1'b0;
         end
         void'(sq[win].pop_front());
         mptr = (win + 1) % NI;
      end
      cycles++;
   endtask

   task automatic add_packet(int i);
      int n;
      sq[i].push_back({2'($urandom), 2'($urandom), 4'h0});
      n = $urandom % 4;
      for (int k = 0; k < n; k++) sq[i].push_back(8'($urandom % 255));
      sq[i].push_back(8'hFF);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 180000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      finish_run();
   end

   initial begin
      logic [7:0] exp2 [6] = '{8'h50, 8'h11, 8'hFF, 8'hD0, 8'h33, 8'hFF};
      logic [7:0] exp3 [3] = '{8'h90, 8'h22, 8'h23};
      mptr = 0;
      for (int i = 0; i < NI; i++) begin mb[i] = 0; mbch[i] = 0; end
      for (int k = 0; k < NC; k++) mown[k] = 0;
      rst_n = 1'b0; in_valid = '0; in_flit = '0; out_pop = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == '0, "R1 out_valid in reset", 64'(out_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(out_valid == '0, "R1 out_valid after reset", 64'(out_valid), 64'h0);
      chk(in_ready == '0, "R1 in_ready idle", 64'(in_ready), 64'h0);

      // directed: contention for port 1
      sq[0] = '{8'h50, 8'h11, 8'hFF};
      sq[1] = '{8'h90, 8'h22, 8'h23};
      sq[2] = '{8'hD0, 8'h33, 8'hFF};
      repeat (12) step();
      chk(out_valid == 8'b0000_1100, "R2 R3 header routed to port 1 channels", 64'(out_valid), 64'h0C);
      chk(in_valid[2] && !in_ready[2], "R6 stall on full channel", 64'(in_ready[2]), 64'h0);
      pop_mask = 8'h04;
      for (int j = 0; j < 6; j++) begin
         step();
         chk(out_flit[2*8 +: 8] == exp2[j], "R5 R6 R9 channel 2 order", 64'(out_flit[2*8 +: 8]), 64'(exp2[j]));
      end
      pop_mask = 8'h08;
      for (int j = 0; j < 3; j++) begin
         step();
         chk(out_flit[3*8 +: 8] == exp3[j], "R3 R4 channel 3 order", 64'(out_flit[3*8 +: 8]), 64'(exp3[j]));
      end
      step();                      // pop on empty channel 3
      pop_mask = '0;
      step();
      chk(out_valid[3] == 1'b0, "R9 pop on empty ignored", 64'(out_valid[3]), 64'h0);
      sq[1].push_back(8'hFF);
      repeat (2) step();
      chk(out_valid[3] && out_flit[3*8 +: 8] == 8'hFF, "R4 tail follows binding", 64'(out_flit[3*8 +: 8]), 64'hFF);
      pop_mask = 8'hFF;
      repeat (3) step();
      pop_mask = '0;

      // directed: all four sources at once
      sq[0] = '{8'h00, 8'hFF};
      sq[1] = '{8'h10, 8'hFF};
      sq[2] = '{8'h20, 8'hFF};
      sq[3] = '{8'h30, 8'hFF};
      step(); step();
      chk($countones(out_valid) == 1, "R7 one flit per cycle", 64'($countones(out_valid)), 64'd1);
      repeat (3) step();
      chk(out_valid == 8'b0101_0101, "R2 R7 four ports reached", 64'(out_valid), 64'h55);
      repeat (6) step();
      pop_mask = 8'hFF;
      repeat (4) step();
      pop_mask = '0;

      // random traffic
      gate_mod = 3; rand_pop = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < NI; i++) if (sq[i].size() < 4) add_packet(i);
         step();
      end
      // drain
      gate_mod = 0; pop_mask = 8'hFF;
      for (int n = 0; n < 2000; n++) begin
         if (sq[0].size() + sq[1].size() + sq[2].size() + sq[3].size() == 0) break;
         step();
      end
      repeat (10) step();
      chk(out_valid == '0, "R9 all channels drained", 64'(out_valid), 64'h0);
      finish_run();
   end

endmodule